// File: doc/BRIEF.md
# System Tick Down-Counter Timer

A register-mapped periodic timer built around a 24-bit down-counter. Software programs a reload value, picks the count source (every core clock, or only on cycles where an external reference tick enable is high) and sets the enable bit. The counter loads the reload value and steps down once per tick. A wrap is the tick on which the counter already holds zero. A wrap sets a sticky count flag, reloads the counter and, when the interrupt bit is set, sends a one-cycle pend request to the interrupt controller. A reload value of zero at wrap time turns the timer off.

The register port is a plain strobe interface. `wr_en` with `addr` and `wdata` writes at the clock edge. `rd_en` with `addr` returns combinational `rdata` in the same cycle, and any read side effect takes place at the next edge. Four word registers are decoded: control/status, reload, current value and a constant calibration word.

Two states hold the run status. HALT means the counter is stopped. RUN means it counts. The ARM transition goes HALT→RUN on a control write with bit 0 set, and it loads the counter. The DISARM transition goes RUN→HALT on a control write with bit 0 clear. The EXHAUST transition goes RUN→HALT on a wrap while the reload value is zero, as long as no control write happens in that cycle. HOLD keeps the current state in every other case.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset every register reads zero, the timer is in HALT and `pend_req` is low.
- R2: Register offsets are 0x10 control, 0x14 reload, 0x18 current value and 0x1C calibration. Control bit 0 is enable, bit 1 is interrupt enable, bit 2 is source select and bit 16 is the count flag. All other bits read zero. Reload and current value are 24 bits wide and their upper bits read zero. An unmapped offset, or a cycle with `rd_en` low, reads 0.
- R3: A control write changes only bits 2:0. The count flag is not changed by a control write.
- R4: ARM loads the counter with the reload value. From then on a wrap occurs every reload+1 ticks.
- R5: A wrap sets the count flag. If the interrupt bit is 1, `pend_req` is high for exactly the one cycle after the wrap edge. If the interrupt bit is 0, no pulse is sent.
- R6: A control read returns the current flag and clears it at that edge. A wrap in the same cycle wins, and the flag stays set.
- R7: A write to the current-value register, whatever its data, reloads the counter and clears the count flag.
- R8: A wrap while the reload value is zero clears the enable bit and stops counting (EXHAUST).
- R9: The current-value register reads 0 while the timer is in HALT. The calibration register always reads 10000.
- R10: With source select at 1 the counter steps every clock. With source select at 0 it steps only on cycles where `ref_tick` is high, and otherwise holds its value.
- R11: Clearing enable stops the count (DISARM). Setting it again reloads the counter from the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte offset of the register |
| wdata | input | 32 | Write data |
| ref_tick | input | 1 | External reference tick enable |
| rdata | output | 32 | Read data, zero when `rd_en` is low |
| pend_req | output | 1 | One-cycle interrupt pend request |

## Verification
The bench uses the default parameters: a 12-bit address, a 24-bit count and a calibration constant of 10000. It programs the reload register with all ones to show the truncation to 24 bits. It then uses small reload values (0, 4, 40), so that wrap periods, exhaustion on a zero reload and flag races happen within a few dozen cycles. Holding the reference tick low or pulsing it every third cycle, with the core-clock source deselected, checks both hold and stepping under the external tick.

// File: rtl/st_tick_pkg.sv
package st_tick_pkg;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } tick_state_e;

    localparam int unsigned NUM_REGS = 4;
    localparam int unsigned IDX_CTRL = 0;
    localparam int unsigned IDX_RLD  = 1;
    localparam int unsigned IDX_CUR  = 2;
    localparam int unsigned IDX_CAL  = 3;

    localparam int unsigned BIT_EN   = 0;
    localparam int unsigned BIT_IRQ  = 1;
    localparam int unsigned BIT_SRC  = 2;
    localparam int unsigned BIT_FLAG = 16;

    function automatic int unsigned reg_offset(input int unsigned idx);
        int unsigned ofs;
        unique case (idx)
            IDX_CTRL: ofs = 32'h010;
            IDX_RLD:  ofs = 32'h014;
            IDX_CUR:  ofs = 32'h018;
            default:  ofs = 32'h01C;
        endcase
        return ofs;
    endfunction

endpackage

// File: rtl/st_addr_dec.sv
module st_addr_dec
    import st_tick_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] hit
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
        assign hit[g] = (addr == ADDR_W'(reg_offset(g)));
    end

endmodule

// File: rtl/st_ctrl_fsm.sv
module st_ctrl_fsm
    import st_tick_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [2:0] cfg_data,
    input  logic       wrap,
    input  logic       reload_zero,
    input  logic       flag_clr,
    output logic       run,
    output logic       start,
    output logic       irq_en,
    output logic       core_src,
    output logic       flag,
    output logic       pend
);

    tick_state_e state_q;
    tick_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: ARM, DISARM, EXHAUST, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: begin
                if (cfg_wr && cfg_data[BIT_EN]) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (cfg_wr) begin
                    if (!cfg_data[BIT_EN]) begin
                        state_d = ST_HALT;
                    end
                end else if (wrap && reload_zero) begin
                    state_d = ST_HALT;
                end
            end
            default: state_d = ST_HALT;
        endcase
    end

    // State-derived outputs
    always_comb begin
        run   = (state_q == ST_RUN);
        start = (state_q == ST_HALT) && cfg_wr && cfg_data[BIT_EN];
    end

    // Configuration bits, sticky flag, pend pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en   <= 1'b0;
            core_src <= 1'b0;
            flag     <= 1'b0;
            pend     <= 1'b0;
        end else begin
            if (cfg_wr) begin
                irq_en   <= cfg_data[BIT_IRQ];
                core_src <= cfg_data[BIT_SRC];
            end
            if (wrap) begin
                flag <= 1'b1;
            end else if (flag_clr) begin
                flag <= 1'b0;
            end
            pend <= wrap && irq_en;
        end
    end

endmodule

// File: rtl/st_down_counter.sv
module st_down_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt,
    output logic             at_zero
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign at_zero = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= reload_val;
        end else if (step) begin
            cnt <= at_zero ? reload_val : (cnt - ONE);
        end
    end

endmodule

// File: rtl/st_read_mux.sv
module st_read_mux
    import st_tick_pkg::*;
#(
    parameter int CNT_W     = 24,
    parameter int DATA_W    = 32,
    parameter int CALIB_VAL = 10000
) (
    input  logic                rd_en,
    input  logic [NUM_REGS-1:0] hit,
    input  logic                run,
    input  logic                irq_en,
    input  logic                core_src,
    input  logic                flag,
    input  logic [CNT_W-1:0]    reload_val,
    input  logic [CNT_W-1:0]    cnt,
    output logic [DATA_W-1:0]   rdata
);

    logic [DATA_W-1:0] ctrl_word;

    always_comb begin
        ctrl_word           = '0;
        ctrl_word[BIT_EN]   = run;
        ctrl_word[BIT_IRQ]  = irq_en;
        ctrl_word[BIT_SRC]  = core_src;
        ctrl_word[BIT_FLAG] = flag;
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (hit[IDX_CTRL]) begin
                rdata = ctrl_word;
            end else if (hit[IDX_RLD]) begin
                rdata = DATA_W'(reload_val);
            end else if (hit[IDX_CUR]) begin
                rdata = run ? DATA_W'(cnt) : '0;
            end else if (hit[IDX_CAL]) begin
                rdata = DATA_W'(CALIB_VAL);
            end
        end
    end

endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
    import st_tick_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 24,
    parameter int CALIB_VAL = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ref_tick,
    output logic [DATA_W-1:0] rdata,
    output logic              pend_req
);

    logic [NUM_REGS-1:0] hit;
    logic                wr_ctrl, wr_rld, wr_cur, rd_ctrl;
    logic [CNT_W-1:0]    reload_q;
    logic [CNT_W-1:0]    cnt;
    logic                at_zero, run, start, irq_en, core_src, flag;
    logic                tick, wrap;
    logic                unused_wdata;

    st_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .hit  (hit)
    );

    assign wr_ctrl = wr_en && hit[IDX_CTRL];
    assign wr_rld  = wr_en && hit[IDX_RLD];
    assign wr_cur  = wr_en && hit[IDX_CUR];
    assign rd_ctrl = rd_en && hit[IDX_CTRL];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (wr_rld) begin
            reload_q <= wdata[CNT_W-1:0];
        end
    end

    assign unused_wdata = ^wdata[DATA_W-1:CNT_W];

    assign tick = core_src ? 1'b1 : ref_tick;
    assign wrap = run && tick && at_zero;

    st_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (wr_ctrl),
        .cfg_data    (wdata[2:0]),
        .wrap        (wrap),
        .reload_zero (reload_q == '0),
        .flag_clr    (rd_ctrl || wr_cur),
        .run         (run),
        .start       (start),
        .irq_en      (irq_en),
        .core_src    (core_src),
        .flag        (flag),
        .pend        (pend_req)
    );

    st_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (wr_cur || start),
        .step       (run && tick),
        .reload_val (reload_q),
        .cnt        (cnt),
        .at_zero    (at_zero)
    );

    st_read_mux #(
        .CNT_W     (CNT_W),
        .DATA_W    (DATA_W),
        .CALIB_VAL (CALIB_VAL)
    ) u_rmux (
        .rd_en      (rd_en),
        .hit        (hit),
        .run        (run),
        .irq_en     (irq_en),
        .core_src   (core_src),
        .flag       (flag),
        .reload_val (reload_q),
        .cnt        (cnt),
        .rdata      (rdata)
    );

endmodule

// File: rtl/st_tick_chk.sv
module st_tick_chk
    import st_tick_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic              en_bit,
    input logic              pend_req,
    input logic              run,
    input logic              flag,
    input logic              tick,
    input logic              at_zero,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  reload_q
);

    logic at_ctrl, at_cur, wrap_seen;
    assign at_ctrl   = (addr == ADDR_W'(reg_offset(IDX_CTRL)));
    assign at_cur    = (addr == ADDR_W'(reg_offset(IDX_CUR)));
    assign wrap_seen = run && tick && at_zero;

    // R5
    pend_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_req |-> flag);

    // R7
    cur_write_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && at_cur) |=> (cnt == $past(reload_q)));

    // R6
    ctrl_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && at_ctrl && !wrap_seen) |=> !flag);

    // R4
    arm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && wr_en && at_ctrl && en_bit) |=> (run && cnt == $past(reload_q)));

    // R8
    exhaust_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_seen && reload_q == '0 && !(wr_en && at_ctrl)) |=> !run);

    // R10
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && !wr_en) |=> $stable(cnt));

endmodule

bind sys_tick_timer st_tick_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .en_bit   (wdata[0]),
    .pend_req (pend_req),
    .run      (run),
    .flag     (flag),
    .tick     (tick),
    .at_zero  (at_zero),
    .cnt      (cnt),
    .reload_q (reload_q)
);

// File: tb/sys_tick_timer_bench.sv
`timescale 1ns/1ps
module sys_tick_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        ref_tick = 1'b0;
    logic [31:0] rdata;
    logic        pend_req;

    int    nvec = 0;
    int    nfail = 0;
    int    cyc = 0;
    int    npend = 0;
    int    ref_cyc = 0;
    bit    ref_mode = 0;
    int    pend_q[$];
    string cur_req = "R1";

    // behavioural reference state
    bit        m_run, m_tint, m_csrc, m_flag, m_pend;
    int        m_cnt, m_rel;

    always #5 clk = ~clk;

    sys_tick_timer u_sys_tick_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .ref_tick(ref_tick), .rdata(rdata), .pend_req(pend_req)
    );

    function automatic logic [31:0] model_rdata();
        logic [31:0] v;
        v = 32'h0;
        if (rd_en) begin
            case (addr)
                12'h010: v = (32'(m_flag) << 16) | (32'(m_csrc) << 2) | (32'(m_tint) << 1) | 32'(m_run);
                12'h014: v = 32'(m_rel);
                12'h018: v = m_run ? 32'(m_cnt) : 32'h0;
                12'h01C: v = 32'd10000;
                default: v = 32'h0;
            endcase
        end
        return v;
    endfunction

    always @(posedge clk) begin : model
        bit tk, wc, wl, wv, rc, wp, n_run;
        int n_cnt;
        if (!rst_n) begin
            m_run = 0; m_tint = 0; m_csrc = 0; m_flag = 0; m_pend = 0;
            m_cnt = 0; m_rel = 0;
        end else begin
            tk = m_csrc || ref_tick;
            wc = wr_en && addr == 12'h010;
            wl = wr_en && addr == 12'h014;
            wv = wr_en && addr == 12'h018;
            rc = rd_en && addr == 12'h010;
            wp = m_run && tk && m_cnt == 0;
            n_cnt = m_cnt;
            if (wv) n_cnt = m_rel;
            else if (!m_run && wc && wdata[0]) n_cnt = m_rel;
            else if (m_run && tk) n_cnt = (m_cnt == 0) ? m_rel : m_cnt - 1;
            n_run = m_run;
            if (wc) n_run = wdata[0];
            else if (wp && m_rel == 0) n_run = 0;
            m_pend = wp && m_tint;
            if (wp) m_flag = 1;
            else if (rc || wv) m_flag = 0;
            if (wc) begin m_tint = wdata[1]; m_csrc = wdata[2]; end
            if (wl) m_rel = int'(wdata & 32'h00FF_FFFF);
            m_cnt = n_cnt;
            m_run = n_run;
        end
    end

    // per-clock comparison against the model
    initial forever begin
        @(posedge clk);
        #3;
        cyc++;
        if (rst_n) begin
            nvec++;
            if (rdata !== model_rdata() || pend_req !== m_pend) begin
                nfail++;
                $display("FAIL %s cycle %0d: rdata=%h pend=%b expected rdata=%h pend=%b",
                         cur_req, cyc, rdata, pend_req, model_rdata(), m_pend);
            end
            if (pend_req) begin
                npend++;
                pend_q.push_back(cyc);
            end
        end
    end

    // reference tick generator
    initial forever begin
        @(negedge clk);
        ref_cyc++;
        ref_tick = ref_mode && (ref_cyc % 3 == 0);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #2 v = rdata;
        @(negedge clk);
        rd_en = 1'b0; addr = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] v, v1, v2;
        int p0;
        bit gaps_ok;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R1";
        rd(12'h010, v); chk("R1 ctrl", v, 32'h0);
        rd(12'h014, v); chk("R1 reload", v, 32'h0);
        rd(12'h018, v); chk("R1 current", v, 32'h0);
        chk("R1 pend", 32'(pend_req), 32'h0);

        cur_req = "R9";
        rd(12'h01C, v); chk("R9 calibration", v, 32'd10000);
        cur_req = "R2";
        rd(12'h020, v); chk("R2 unmapped", v, 32'h0);
        wr(12'h014, 32'hFFFF_FFFF);
        rd(12'h014, v); chk("R2 reload width", v, 32'h00FF_FFFF);

        cur_req = "R3";
        wr(12'h010, 32'hFFFF_FFF6);
        rd(12'h010, v); chk("R3 ctrl bits", v, 32'h0000_0006);

        cur_req = "R4";
        wr(12'h014, 32'd4);
        wr(12'h010, 32'h7);
        pend_q.delete();
        idle(30);
        wr(12'h010, 32'h6);
        gaps_ok = (pend_q.size() >= 3);
        for (int i = 1; i < pend_q.size(); i++)
            if (pend_q[i] - pend_q[i-1] != 5) gaps_ok = 0;
        chk("R4 R5 period reload+1", 32'(gaps_ok), 32'h1);

        cur_req = "R6";
        rd(12'h010, v); chk("R6 flag seen", v, 32'h0001_0006);
        rd(12'h010, v); chk("R6 flag cleared", v, 32'h0000_0006);

        cur_req = "R5";
        p0 = npend;
        wr(12'h010, 32'h5);
        idle(20);
        wr(12'h010, 32'h4);
        chk("R5 no pend without irq", 32'(npend - p0), 32'h0);
        rd(12'h010, v); chk("R5 flag without irq", v, 32'h0001_0004);

        cur_req = "R7";
        wr(12'h014, 32'd40);
        wr(12'h010, 32'h7);
        idle(45);
        wr(12'h018, 32'h0000_0123);
        rd(12'h018, v); chk("R7 current reloaded", v, 32'd39);
        rd(12'h010, v); chk("R7 flag cleared", v, 32'h0000_0007);

        cur_req = "R10";
        ref_mode = 0;
        wr(12'h010, 32'h3);
        rd(12'h018, v1);
        idle(10);
        rd(12'h018, v2); chk("R10 hold without ref tick", v2, v1);
        ref_mode = 1;
        idle(30);
        rd(12'h018, v2); chk("R10 steps on ref tick", 32'(v2 < v1), 32'h1);

        cur_req = "R11";
        ref_mode = 0;
        wr(12'h010, 32'h2);
        rd(12'h018, v); chk("R11 R9 halted reads zero", v, 32'h0);
        wr(12'h010, 32'h3);
        rd(12'h018, v); chk("R11 re-enable reloads", v, 32'd40);

        cur_req = "R8";
        wr(12'h010, 32'h7);
        wr(12'h014, 32'd0);
        idle(60);
        rd(12'h010, v); chk("R8 enable cleared", v, 32'h0001_0006);
        rd(12'h018, v); chk("R8 stopped current", v, 32'h0);

        idle(3);
        finish_run();
    end

endmodule